// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Option and Protection Register

This block pairs a free-running watchdog timer with one byte-wide control register that the CPU reaches at a single address. Firmware keeps the watchdog from firing by writing a byte to that register with the low bit cleared. If no such write arrives within the timeout window, the block emits a one-clock reset request and starts timing again from zero. The same register holds an optional-features enable bit, which reads back, and a code-protection bit. The protection bit is write-only and sticky. Once it is set, any external access to the protected code window is flagged.

The watchdog counts only while the non-volatile configuration enables it. The power mode also gates it. Run, wait and halt let it count. Stop clears the counter and freezes it, unless a configuration input tells the block to treat stop as halt. A flag meaning the programming pin carries high voltage overrides everything else and holds the watchdog at zero until the flag drops. The option and protection bits are cleared only by the power-on reset. The ordinary reset input leaves them untouched.

Top module: `cop_optreg`

## Requirements
- R1: A CPU write to address 0x1FF0 whose data bit 0 is 0 sets the watchdog count to zero on that clock. No reset pulse follows until the full timeout elapses again.
- R2: Counting from zero, the TIMEOUT-th consecutive counting clock drives `cop_rst` high for exactly one clock. On that same clock the count returns to zero, so the next pulse comes TIMEOUT counting clocks later.
- R3: The watchdog counts in run (mode 0), wait (mode 1) and halt (mode 2) only while `cfg_cop_en` is 1. While `cfg_cop_en` is 0 the count is held at zero and `cop_rst` stays low.
- R4: In stop (mode 3) with `cfg_stop_as_halt` at 0, the count is cleared and frozen and no pulse is produced. After returning to run, a full TIMEOUT window from zero is needed.
- R5: With `cfg_stop_as_halt` at 1, stop mode counts exactly like halt.
- R6: While `vpp_high` is 1, the count is held at zero and `cop_rst` stays low. Counting resumes from zero once the flag drops.
- R7: Only address 0x1FF0 is decoded, and a write elsewhere changes nothing. Bit 0 is the clear bit, bit 1 the protection bit and bit 2 the optional-features bit. A read of 0x1FF0 returns bit 2 as stored and 0 in every other bit. `bus_rdata` is 0 when no read hits the register.
- R8: `opt_en` takes data bit 2 on every write to the register: 1 enables, 0 disables.
- R9: `sec_set` goes to 1 on a register write with data bit 1 at 1. A later write of 0 does not clear it, and neither does `rst_n`. Only `por_n` clears it. `rst_n` likewise leaves `opt_en` unchanged.
- R10: `ext_protect` is 1 exactly when `sec_set` is 1 and `ext_addr` lies within 0x0700 to 0x1FFF inclusive.
- R11: A register write whose data bit 0 is 1 does not restart the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous system reset for the watchdog timer |
| por_n | input | 1 | Active-low power-on reset; also clears the option and protection bits |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Register read data, 0 when not selected |
| pwr_mode | input | 2 | Power mode: 0 run, 1 wait, 2 halt, 3 stop |
| cfg_cop_en | input | 1 | Configuration: watchdog enabled |
| cfg_stop_as_halt | input | 1 | Configuration: treat stop as halt |
| vpp_high | input | 1 | Programming pin is at high voltage |
| ext_addr | input | 16 | Address of an external access to be screened |
| cop_rst | output | 1 | One-clock watchdog reset request |
| opt_en | output | 1 | Optional features enabled |
| sec_set | output | 1 | Sticky code-protection flag |
| ext_protect | output | 1 | External access falls in the protected window |

## Verification
The bench builds the block with TIMEOUT set to 16. At that value every timer path fits in a few dozen clocks: the exact pulse clock, the automatic restart, the clear-on-stop and high-voltage holds, and the counting in each mode. The register address and the protected window keep their default values. This lets the bench probe the window edges 0x06FF, 0x0700, 0x1FFF and 0x2000 directly.

// File: rtl/cop_optreg_pkg.sv
package cop_optreg_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_HALT = 2'd2,
    PM_STOP = 2'd3
  } pwr_mode_e;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned CLR_BIT = 0;
  localparam int unsigned SEC_BIT = 1;
  localparam int unsigned OPT_BIT = 2;

endpackage

// File: rtl/cop_optreg_timer.sv
module cop_optreg_timer #(
  parameter int unsigned TIMEOUT = 32768,
  localparam int unsigned CNT_W  = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             exp_d, exp_q;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (restart || !run_en) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      exp_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt    = cnt_q;
  assign expire = exp_q;

endmodule

// File: rtl/cop_optreg_regs.sv
module cop_optreg_regs
  import cop_optreg_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              opt,
  output logic              sec
);

  logic opt_d, opt_q;
  logic sec_d, sec_q;

  always_comb begin
    opt_d = opt_q;
    sec_d = sec_q;
    if (wr_hit) begin
      opt_d = wdata[OPT_BIT];
      sec_d = sec_q | wdata[SEC_BIT];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      opt_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      opt_q <= opt_d;
      sec_q <= sec_d;
    end
  end

  assign opt = opt_q;
  assign sec = sec_q;

endmodule

// File: rtl/cop_optreg_window.sv
module cop_optreg_window #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] LO = 16'h0700,
  parameter logic [AW-1:0] HI = 16'h1FFF
) (
  input  logic          arm,
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic in_lo, in_hi;

  always_comb begin
    in_lo = (addr >= LO);
    in_hi = (addr <= HI);
    hit   = arm && in_lo && in_hi;
  end

endmodule

// File: rtl/cop_optreg.sv
module cop_optreg
  import cop_optreg_pkg::*;
#(
  parameter int unsigned TIMEOUT  = 32768,
  parameter logic [15:0] REG_ADDR = 16'h1FF0,
  parameter logic [15:0] PROT_LO  = 16'h0700,
  parameter logic [15:0] PROT_HI  = 16'h1FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [1:0]  pwr_mode,
  input  logic        cfg_cop_en,
  input  logic        cfg_stop_as_halt,
  input  logic        vpp_high,
  input  logic [15:0] ext_addr,
  output logic        cop_rst,
  output logic        opt_en,
  output logic        sec_set,
  output logic        ext_protect
);

  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  logic             sel;
  logic             wr_hit;
  logic             kick;
  logic             stop_eff;
  logic             run_en;
  logic             tmr_rst_n;
  logic [CNT_W-1:0] cop_cnt;
  logic             opt_q, sec_q;

  always_comb begin
    sel       = (bus_addr == REG_ADDR);
    wr_hit    = sel && bus_wr;
    kick      = wr_hit && !bus_wdata[CLR_BIT];
    stop_eff  = (pwr_mode_e'(pwr_mode) == PM_STOP) && !cfg_stop_as_halt;
    run_en    = cfg_cop_en && !vpp_high && !stop_eff;
    tmr_rst_n = rst_n && por_n;
  end

  cop_optreg_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (tmr_rst_n),
    .run_en  (run_en),
    .restart (kick),
    .cnt     (cop_cnt),
    .expire  (cop_rst)
  );

  cop_optreg_regs u_regs (
    .clk    (clk),
    .por_n  (por_n),
    .wr_hit (wr_hit),
    .wdata  (bus_wdata),
    .opt    (opt_q),
    .sec    (sec_q)
  );

  cop_optreg_window #(.AW(16), .LO(PROT_LO), .HI(PROT_HI)) u_window (
    .arm  (sec_q),
    .addr (ext_addr),
    .hit  (ext_protect)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel && bus_rd) bus_rdata[OPT_BIT] = opt_q;
  end

  assign opt_en  = opt_q;
  assign sec_set = sec_q;

endmodule

// File: rtl/cop_optreg_chk.sv
module cop_optreg_chk #(
  parameter int unsigned TIMEOUT  = 32768,
  parameter logic [15:0] REG_ADDR = 16'h1FF0,
  localparam int unsigned CNT_W   = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic [15:0]      bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic [1:0]       pwr_mode,
  input logic             cfg_cop_en,
  input logic             cfg_stop_as_halt,
  input logic             vpp_high,
  input logic             cop_rst,
  input logic             sec_set,
  input logic             ext_protect,
  input logic [CNT_W-1:0] cop_cnt
);

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_wr && bus_addr == REG_ADDR && !bus_wdata[0]) |=> (cop_cnt == '0 && !cop_rst));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    cop_rst |=> !cop_rst);

  assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !cfg_cop_en |=> (cop_cnt == '0 && !cop_rst));

  assert_stop_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (pwr_mode == 2'd3 && !cfg_stop_as_halt) |=> (cop_cnt == '0 && !cop_rst));

  assert_vpp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    vpp_high |=> (cop_cnt == '0 && !cop_rst));

  assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !bus_rd |-> (bus_rdata == 8'h00));

  assert_read_mask_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    bus_rd |-> (bus_rdata[7:3] == 5'd0 && bus_rdata[1:0] == 2'd0));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    sec_set |=> sec_set);

  assert_window_R10: assert property (@(posedge clk) disable iff (!por_n)
    ext_protect |-> sec_set);

endmodule

bind cop_optreg cop_optreg_chk #(.TIMEOUT(TIMEOUT), .REG_ADDR(REG_ADDR)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .por_n            (por_n),
  .bus_addr         (bus_addr),
  .bus_wr           (bus_wr),
  .bus_rd           (bus_rd),
  .bus_wdata        (bus_wdata),
  .bus_rdata        (bus_rdata),
  .pwr_mode         (pwr_mode),
  .cfg_cop_en       (cfg_cop_en),
  .cfg_stop_as_halt (cfg_stop_as_halt),
  .vpp_high         (vpp_high),
  .cop_rst          (cop_rst),
  .sec_set          (sec_set),
  .ext_protect      (ext_protect),
  .cop_cnt          (cop_cnt)
);

// File: tb/cop_optreg_test.sv
module cop_optreg_test;

  localparam int unsigned TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n, por_n;
  logic [15:0] bus_addr, ext_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [1:0]  pwr_mode;
  logic        cfg_cop_en, cfg_stop_as_halt, vpp_high;
  logic        cop_rst, opt_en, sec_set, ext_protect;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #4 clk = ~clk;

  cop_optreg #(.TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_mode(pwr_mode), .cfg_cop_en(cfg_cop_en),
    .cfg_stop_as_halt(cfg_stop_as_halt), .vpp_high(vpp_high),
    .ext_addr(ext_addr), .cop_rst(cop_rst), .opt_en(opt_en),
    .sec_set(sec_set), .ext_protect(ext_protect)
  );

  always @(negedge clk) if (cop_rst) pulses <= pulses + 1;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [15:0] xaddr;
    logic [7:0]  e_rdata;
    logic        e_opt;
    logic        e_sec;
    logic        e_prot;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b1, 16'h1FF0, 8'h00, 16'h0800, 8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h1FF0, 8'h04, 16'h0700, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h1FF0, 8'h00, 16'h0700, 8'h04, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h1FF1, 8'h00, 16'h0700, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h1FF1, 8'h02, 16'h0700, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h1FF0, 8'h00, 16'h0700, 8'h04, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h1FF0, 8'hFB, 16'h0700, 8'h00, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 16'h1FF0, 8'h00, 16'h06FF, 8'h00, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 16'h1FF0, 8'h00, 16'h1FFF, 8'h00, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 16'h1FF0, 8'h00, 16'h2000, 8'h00, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 16'h1FF0, 8'h07, 16'h1000, 8'h00, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 16'h1FF0, 8'h00, 16'h1000, 8'h04, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_expect(input int n, input int exp_pulses, input string req);
    int base;
    base = pulses;
    step(n);
    check(req, 16'(pulses - base), 16'(exp_pulses));
  endtask

  task automatic reg_write(input logic [7:0] d);
    bus_addr = 16'h1FF0; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: bench hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_n = 1'b0;
    bus_addr = 16'h0000; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
    pwr_mode = 2'd0; cfg_cop_en = 1'b0; cfg_stop_as_halt = 1'b0; vpp_high = 1'b0;
    ext_addr = 16'h1000;
    step(3);
    rst_n = 1'b1; por_n = 1'b1;
    step(1);

    // reset state
    check("R2 reset cop_rst", 16'(cop_rst), 16'd0);
    check("R9 reset sec_set", 16'(sec_set), 16'd0);
    check("R8 reset opt_en", 16'(opt_en), 16'd0);
    check("R10 reset ext_protect", 16'(ext_protect), 16'd0);
    check("R7 idle rdata", 16'(bus_rdata), 16'd0);

    // register / window vector table (R7 R8 R9 R10)
    foreach (VECS[i]) begin
      bus_wr = VECS[i].wr; bus_rd = VECS[i].rd; bus_addr = VECS[i].addr;
      bus_wdata = VECS[i].wdata; ext_addr = VECS[i].xaddr;
      step(1);
      check($sformatf("R7 vec%0d rdata", i), 16'(bus_rdata), 16'(VECS[i].e_rdata));
      check($sformatf("R8 vec%0d opt_en", i), 16'(opt_en), 16'(VECS[i].e_opt));
      check($sformatf("R9 vec%0d sec_set", i), 16'(sec_set), 16'(VECS[i].e_sec));
      check($sformatf("R10 vec%0d ext_protect", i), 16'(ext_protect), 16'(VECS[i].e_prot));
    end
    bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;

    // system reset keeps register
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    check("R9 sec survives rst_n", 16'(sec_set), 16'd1);
    check("R8 opt survives rst_n", 16'(opt_en), 16'd1);
    por_n = 1'b0; step(2); por_n = 1'b1; step(1);
    check("R9 sec cleared by por_n", 16'(sec_set), 16'd0);
    check("R8 opt cleared by por_n", 16'(opt_en), 16'd0);
    ext_addr = 16'h0700;
    step(1);
    check("R10 no protect after por", 16'(ext_protect), 16'd0);

    // disabled watchdog
    run_expect(3 * TMO, 0, "R3 disabled no pulse");

    // timeout timing from a clear
    cfg_cop_en = 1'b1;
    reg_write(8'h00);
    run_expect(TMO - 1, 0, "R2 before timeout");
    run_expect(1, 1, "R2 pulse at timeout");
    check("R2 pulse level", 16'(cop_rst), 16'd1);
    run_expect(1, 0, "R2 single cycle");
    run_expect(TMO - 2, 0, "R2 restart quiet");
    run_expect(1, 1, "R2 second pulse");

    // periodic clears keep it quiet
    reg_write(8'h00);
    for (int k = 0; k < 6; k++) begin
      run_expect(TMO - 4, 0, "R1 serviced no pulse");
      reg_write(8'hF8);
    end

    // writes with bit0=1 do not clear
    reg_write(8'h00);
    run_expect(5, 0, "R11 lead");
    reg_write(8'h01);
    run_expect(TMO - 7, 0, "R11 still counting");
    run_expect(1, 1, "R11 timeout despite write");

    // wait and halt modes count
    pwr_mode = 2'd1;
    reg_write(8'h00);
    run_expect(TMO - 1, 0, "R3 wait quiet");
    run_expect(1, 1, "R3 wait timeout");
    pwr_mode = 2'd2;
    reg_write(8'h00);
    run_expect(TMO - 1, 0, "R3 halt quiet");
    run_expect(1, 1, "R3 halt timeout");

    // enable from zero after disable
    cfg_cop_en = 1'b0;
    pwr_mode = 2'd0;
    step(5);
    cfg_cop_en = 1'b1;
    run_expect(TMO - 1, 0, "R3 re-enable quiet");
    run_expect(1, 1, "R3 re-enable timeout");

    // stop clears and freezes
    reg_write(8'h00);
    run_expect(10, 0, "R4 lead");
    pwr_mode = 2'd3;
    run_expect(3 * TMO, 0, "R4 stop no pulse");
    pwr_mode = 2'd0;
    run_expect(TMO - 1, 0, "R4 full window after stop");
    run_expect(1, 1, "R4 timeout after stop");

    // stop treated as halt
    cfg_stop_as_halt = 1'b1;
    pwr_mode = 2'd3;
    reg_write(8'h00);
    run_expect(TMO - 1, 0, "R5 stop-as-halt quiet");
    run_expect(1, 1, "R5 stop-as-halt timeout");
    cfg_stop_as_halt = 1'b0;
    pwr_mode = 2'd0;

    // high voltage override
    reg_write(8'h00);
    run_expect(10, 0, "R6 lead");
    vpp_high = 1'b1;
    run_expect(3 * TMO, 0, "R6 held off");
    vpp_high = 1'b0;
    run_expect(TMO - 1, 0, "R6 resume from zero");
    run_expect(1, 1, "R6 timeout after drop");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule